// File: doc/BRIEF.md
# Switchable Read Output Path for a Synchronous Burst SRAM

This block is the last stage of a synchronous burst SRAM model: it takes the word the memory array presents and decides what appears on the read data bus, and when. A static mode input picks between two behaviours. With the mode input low, the array word goes to the bus in the same cycle it becomes available (flow-through). With the mode input high, the word is first captured by a rising-edge output register and appears one clock later (pipeline).

A "read data in flight" flag travels through the same stages as the data. Because a deselect or a write clears that flag at the same depth as a read sets it, the bus is released at the same clock edge that read data would have appeared. In pipeline mode this means the bus stays driven for one whole cycle after the edge that samples a deselect and is released after the following edge. The active-low output enable and the active-high sleep input act on the drive enable without waiting for a clock, and neither disturbs the state held in the path.

Top module: `bsr_rd_outpath`

## Requirements
- R1: While `rst_n` is low, and after reset before any read command, `dq_oe` is 0.
- R2: With `pipe_mode` = 0, a read command (`cmd` = 2'b01) sampled at edge k drives the bus after edge k with the array word present in the cycle after edge k.
- R3: With `pipe_mode` = 1, a read command sampled at edge k drives the bus after edge k+1 with the array word that was present in the cycle after edge k.
- R4: The hold code (`cmd` = 2'b00) leaves the previous command in force, so a read followed by holds keeps delivering one array word per cycle.
- R5: A deselect (`cmd` = 2'b11) sampled at edge k releases the bus at the same edge a read sampled at edge k would have driven it: after edge k in flow-through mode, after edge k+1 in pipeline mode, so the previous read stays driven for a full cycle.
- R6: A write (`cmd` = 2'b10) never drives the bus and releases it with the same timing as a deselect.
- R7: `oe_n` high forces `dq_oe` to 0 at once, with no clock edge needed; lowering it restores the drive.
- R8: `sleep` high forces `dq_oe` to 0 at once; the state in the path is kept, so after `sleep` falls the bus shows the word the path would show had sleep never been raised.
- R9: Whenever `dq_oe` is 0, `dq_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 2 | Decoded command: 00 hold, 01 read, 10 write, 11 deselect |
| arr_rdata | input | DATA_W | Word from the memory array, valid in the cycle after the command edge |
| pipe_mode | input | 1 | 1 = registered (pipeline) output, 0 = flow-through |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| sleep | input | 1 | Sleep, active high, asynchronous |
| dq_out | output | DATA_W | Read data bus value |
| dq_oe | output | 1 | Read data bus drive enable |

## Verification
Every sequence of four commands drawn from hold, read, write and deselect is run between flushing deselects, in both modes, and the bus is compared after each edge against a model that looks back through the command history for the last non-hold command at the mode's depth. Read-read-deselect and read-hold patterns separate the flow-through and pipeline latencies and show whether the release edge moves with the mode; write-after-read patterns tell a write that releases the bus from one that drives stale data. A separate directed pass toggles output enable and sleep between clock edges during a held read to show that gating is immediate and that the path keeps its state.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  typedef enum logic [1:0] {
    CMD_HOLD  = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_DESEL = 2'b11
  } bsr_cmd_e;

  // Next value of the "read data in flight" flag for a sampled command.
  function automatic logic next_live(input logic [1:0] code, input logic cur);
    case (code)
      CMD_READ:  return 1'b1;
      CMD_WRITE: return 1'b0;
      CMD_DESEL: return 1'b0;
      default:   return cur;
    endcase
  endfunction

  // Extra clock edges between command and bus for the selected mode.
  function automatic int unsigned extra_edges(input logic pipe);
    return pipe ? 1 : 0;
  endfunction

endpackage

// File: rtl/bsr_cmd_track.sv
module bsr_cmd_track
  import bsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cmd,
  output logic       live_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= next_live(cmd, live_q);
  end

  p_write_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_WRITE) |=> !live_q);

  p_hold_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_HOLD) |=> $stable(live_q));

  p_read_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_READ) |=> live_q);

endmodule

// File: rtl/bsr_out_reg.sv
module bsr_out_reg #(
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              live_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              live_q,
  output logic [DATA_W-1:0] data_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      data_q <= '0;
    end else begin
      live_q <= live_in;
      if (live_in) data_q <= data_in;
    end
  end

  p_pipe_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    live_in |=> live_q);

  p_pipe_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    live_in |=> (data_q == $past(data_in)));

endmodule

// File: rtl/bsr_drive_gate.sv
module bsr_drive_gate #(
  parameter int unsigned DATA_W = 18
) (
  input  logic              pipe_mode,
  input  logic              flow_live,
  input  logic [DATA_W-1:0] flow_data,
  input  logic              reg_live,
  input  logic [DATA_W-1:0] reg_data,
  input  logic              oe_n,
  input  logic              sleep,
  output logic              src_live,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);

  logic [DATA_W-1:0] src_data;

  always_comb begin
    src_live = pipe_mode ? reg_live : flow_live;
    src_data = pipe_mode ? reg_data : flow_data;
    dq_oe    = src_live & ~oe_n & ~sleep;
    dq_out   = dq_oe ? src_data : '0;
  end

endmodule

// File: rtl/bsr_rd_outpath.sv
module bsr_rd_outpath
  import bsr_pkg::*;
#(
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd,
  input  logic [DATA_W-1:0] arr_rdata,
  input  logic              pipe_mode,
  input  logic              oe_n,
  input  logic              sleep,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);

  // Named internal events for the assertions.
  logic              s1_live;
  logic              s2_live;
  logic [DATA_W-1:0] s2_data;
  logic              src_live;

  bsr_cmd_track u_track (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd    (cmd),
    .live_q (s1_live)
  );

  bsr_out_reg #(.DATA_W(DATA_W)) u_oreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .live_in (s1_live),
    .data_in (arr_rdata),
    .live_q  (s2_live),
    .data_q  (s2_data)
  );

  bsr_drive_gate #(.DATA_W(DATA_W)) u_gate (
    .pipe_mode (pipe_mode),
    .flow_live (s1_live),
    .flow_data (arr_rdata),
    .reg_live  (s2_live),
    .reg_data  (s2_data),
    .oe_n      (oe_n),
    .sleep     (sleep),
    .src_live  (src_live),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe)
  );

  always_comb begin
    if (oe_n || sleep) begin
      p_gate_off_r7_r8: assert (!dq_oe);
    end
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!dq_oe);
    end
  end

  p_desel_depth_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_DESEL) |=> ##1 !s2_live);

  p_flow_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && cmd == CMD_DESEL) |=> !dq_oe);

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !src_live |-> (dq_out == '0));

endmodule

// File: tb/bsr_rd_outpath_tb.sv
module bsr_rd_outpath_tb;

  localparam int W = 18;
  localparam int N = 10;
  localparam logic [1:0] C_HOLD = 2'b00, C_READ = 2'b01, C_WRITE = 2'b10, C_DESEL = 2'b11;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   cmd = C_READ;
  logic [W-1:0] arr_rdata = '0;
  logic         pipe_mode = 1'b1;
  logic         oe_n = 1'b0;
  logic         sleep = 1'b0;
  logic [W-1:0] dq_out;
  logic         dq_oe;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bsr_rd_outpath #(.DATA_W(W)) u_dut (
    .clk (clk), .rst_n (rst_n), .cmd (cmd), .arr_rdata (arr_rdata),
    .pipe_mode (pipe_mode), .oe_n (oe_n), .sleep (sleep),
    .dq_out (dq_out), .dq_oe (dq_oe)
  );

  function automatic logic [W-1:0] word_of(input int s, input int i);
    return W'((s * 16 + i) * 37 + 5);
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  logic [1:0] seq [N];

  initial begin
    #(8 * 150000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R1: quiet during and after reset
    repeat (3) @(posedge clk);
    #3 chk("R1 reset", W'(dq_oe), W'(0));
    cmd = C_DESEL;
    rst_n = 1'b1;
    @(posedge clk); #3;
    chk("R1 after reset", W'(dq_oe), W'(0));
    @(posedge clk); #3;
    chk("R1 after reset", W'(dq_oe), W'(0));

    // Sweep: both modes, every 4-command pattern, flushed by deselects.
    for (int m = 0; m < 2; m++) begin
      pipe_mode = m[0];
      for (int s = 0; s < 256; s++) begin
        for (int k = 0; k < N; k++) seq[k] = C_DESEL;
        for (int k = 0; k < 4; k++) seq[3 + k] = 2'((s >> (2 * k)) & 3);
        cmd = seq[0];
        for (int i = 0; i < N; i++) begin
          int idx;
          int last;
          logic exp_on;
          logic [W-1:0] exp_d;
          @(posedge clk);
          #2;
          arr_rdata = word_of(s, i);
          cmd = (i + 1 < N) ? seq[i + 1] : C_DESEL;
          #1;
          idx = i - m;
          if (idx >= 0) begin
            last = idx;
            while (last > 0 && seq[last] == C_HOLD) last--;
            exp_on = (seq[last] == C_READ);
            exp_d  = exp_on ? word_of(s, idx) : '0;
            if (m == 1) chk("R3/R4/R5/R6 pipeline drive", W'(dq_oe), W'(exp_on));
            else        chk("R2/R4/R5/R6 flow drive", W'(dq_oe), W'(exp_on));
            if (exp_on) chk(m == 1 ? "R3 pipeline data" : "R2 flow data", dq_out, exp_d);
            else        chk("R9 idle zero", dq_out, '0);
          end
        end
      end
    end

    // Directed: asynchronous gating during a held pipeline read.
    pipe_mode = 1'b1;
    @(posedge clk); #2;
    cmd = C_READ; arr_rdata = 18'h2A5A5;
    @(posedge clk); #2;
    cmd = C_HOLD;
    @(posedge clk); #3;
    chk("R4 held read driven", W'(dq_oe), W'(1));
    chk("R4 held read data", dq_out, 18'h2A5A5);
    oe_n = 1'b1; #1;
    chk("R7 oe_n off immediate", W'(dq_oe), W'(0));
    chk("R9 oe_n off zero", dq_out, '0);
    oe_n = 1'b0; #1;
    chk("R7 oe_n restore", W'(dq_oe), W'(1));
    sleep = 1'b1; #1;
    chk("R8 sleep off immediate", W'(dq_oe), W'(0));
    @(posedge clk); #2;
    arr_rdata = 18'h1C3C3;
    @(posedge clk); #3;
    chk("R8 sleep still off", W'(dq_oe), W'(0));
    sleep = 1'b0; #1;
    chk("R8 wake drive", W'(dq_oe), W'(1));
    chk("R8 wake data", dq_out, 18'h1C3C3);

    // R5 directed: read-read-deselect in pipeline, release timing
    @(posedge clk); #2;
    cmd = C_DESEL;
    @(posedge clk); #3;
    chk("R5 driven one cycle after deselect", W'(dq_oe), W'(1));
    @(posedge clk); #3;
    chk("R5 released after second edge", W'(dq_oe), W'(0));

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule